// File: doc/BRIEF.md
# Pattern-Driven Column Strobe Sequencer

This block produces the column-address strobe and the read-data capture strobes for one synchronous memory read. It does not use a fixed state sequence for the waveform. Software-style configuration supplies a 96-bit timing pattern, and the block walks through it one bit per fast clock cycle, starting from the least significant bit. The block reads the edges in that bit stream. The first high-to-low edge drops the strobe. Every later low-to-high edge is a candidate data-capture point. Whether a candidate counts depends on the device kind (SDRAM or synchronous ROM) and on whether the memory clock runs at half rate.

A controller pulses `start_i` in the cycle its row strobe or chip select goes active. It then collects one data word per `capture_o` pulse until `done_o` rises. The block also checks the pattern against the encoding rules when the access starts, and reports a pattern that runs out of capture edges as an underrun.

Top module: `cas_seq_top`

## Requirements
- R1: Under synchronous reset, and in idle after reset, `cas_n_o` is 1 and `capture_o`, `done_o`, `beat_cnt_o`, `cfg_err_o` and `underrun_o` are all 0. A reset in the middle of an access returns the block to this state.
- R2: The pattern bit with index k is consumed at the (k+1)-th rising clock edge after the edge that samples `start_i`. The previous bit is taken as 1 before bit 0. `cas_n_o` goes low right after the edge that consumes the first bit that is 0 while its predecessor is 1.
- R3: With `rom_mode_i`=0 (SDRAM), once `cas_n_o` is low it stays low until the edge that raises `done_o`, or until an underrun. Later pattern edges do not change it.
- R4: With `rom_mode_i`=1 (synchronous ROM), `cas_n_o` returns high right after the edge that consumes the first 0-to-1 pattern transition following the fall. This holds even if that transition is not used for capture.
- R5: With `half_clk_i`=0, each 0-to-1 transition after the fall gives `capture_o`=1 for exactly one cycle, right after the edge that consumes it. `beat_cnt_o` (modulo 2^BL_W) then counts the captures of the current access.
- R6: With `half_clk_i`=1, the 1st, 3rd, 5th and later odd-numbered 0-to-1 transitions after the fall are skipped. Only the even-numbered ones produce captures.
- R7: The cycle after the capture of beat number `burst_len_i`, `done_o` is 1 for one cycle and `cas_n_o` is 1. The block is idle in that same cycle.
- R8: If bit 95 is consumed without completing the burst, `underrun_o` rises right after that edge, `cas_n_o` goes high, and the block goes idle. A `burst_len_i` of 0 never completes. `underrun_o` holds until the next accepted start.
- R9: `cfg_err_o` is registered at start and held for the access. It is 1 if any of these holds: the pattern has no fall; it has no later rise; the first rise is more than 2 bits after the first fall; or any bit after the first rise equals its predecessor (the bits must alternate 0,1).
- R10: `cfg_err_o` is also 1 when (`half_clk_i` or `wide_i`) is 1 and pattern bits [1:0] are not both 1.
- R11: A `start_i` pulse during an access is ignored. The pattern, mode and length latched at the accepted start stay in force.
- R12: If the final beat's transition is bit 95 itself, the access completes with `done_o` and without an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse, aligned with row strobe / chip select |
| pattern_i | input | PAT_W | Timing pattern, least significant bit first |
| rom_mode_i | input | 1 | 1 = synchronous ROM, 0 = SDRAM |
| half_clk_i | input | 1 | Memory clock is CPU clock divided by two |
| wide_i | input | 1 | Width flag that demands two leading ones |
| burst_len_i | input | BL_W | Number of beats in the burst |
| cas_n_o | output | 1 | Active-low column strobe |
| capture_o | output | 1 | One-cycle data-capture pulse per beat |
| beat_cnt_o | output | BL_W | Captures made in the current access |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Pattern violates the encoding rules |
| underrun_o | output | 1 | Pattern ended before the burst completed |

## Verification
The capture of the last beat and the end of the pattern can fall on the same edge when the final qualifying transition sits at bit 95. The block must then finish normally rather than report an underrun. The bench provokes this with 66 leading ones and a 15-beat burst, and contrasts it with 68 leading ones, which leaves the burst one edge short. It judges both by the cycle in which `done_o` or `underrun_o` rises and by the level of `cas_n_o`. A sweep over lead length, fall-to-rise gap, device kind, clock rate, width flag and burst length supplies the expected waveform for every cycle, computed arithmetically from the positions of the transitions.

// File: rtl/cas_seq_pkg.sv
package cas_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cas_pattern_check.sv
module cas_pattern_check #(
  parameter int PAT_W = 96
) (
  input  logic [PAT_W-1:0] pattern_i,
  input  logic             need_lead_i,
  output logic             bad_o
);
  always_comb begin
    logic got_fall;
    logic got_rise;
    logic alt_bad;
    logic prv;
    int   fall_pos;
    int   rise_pos;
    got_fall = 1'b0;
    got_rise = 1'b0;
    alt_bad  = 1'b0;
    prv      = 1'b1;
    fall_pos = 0;
    rise_pos = 0;
    for (int i = 0; i < PAT_W; i++) begin
      if (!got_fall) begin
        if (prv && !pattern_i[i]) begin
          got_fall = 1'b1;
          fall_pos = i;
        end
      end else if (!got_rise) begin
        if (!prv && pattern_i[i]) begin
          got_rise = 1'b1;
          rise_pos = i;
        end
      end else if (pattern_i[i] == prv) begin
        alt_bad = 1'b1;
      end
      prv = pattern_i[i];
    end
    bad_o = !got_fall || !got_rise || alt_bad || ((rise_pos - fall_pos) > 2)
            || (need_lead_i && (pattern_i[1:0] != 2'b11));
  end
endmodule

// File: rtl/cas_shift_unit.sv
module cas_shift_unit #(
  parameter int PAT_W = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [PAT_W-1:0] pattern_i,
  output logic             cur_bit_o,
  output logic             prev_bit_o,
  output logic             last_bit_o
);
  localparam int IDX_W = $clog2(PAT_W);

  logic [PAT_W-1:0] sh_q;
  logic             prv_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      prv_q <= 1'b1;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= pattern_i;
      prv_q <= 1'b1;
      idx_q <= '0;
    end else if (adv_i) begin
      sh_q  <= {1'b0, sh_q[PAT_W-1:1]};
      prv_q <= sh_q[0];
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign cur_bit_o  = sh_q[0];
  assign prev_bit_o = prv_q;
  assign last_bit_o = (idx_q == IDX_W'(PAT_W - 1));

  // R8: after the final bit the walk must stop
  assert_stop_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    (adv_i && last_bit_o) |=> !adv_i);
endmodule

// File: rtl/cas_seq_top.sv
module cas_seq_top
  import cas_seq_pkg::*;
#(
  parameter int PAT_W = 96,
  parameter int BL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic             rom_mode_i,
  input  logic             half_clk_i,
  input  logic             wide_i,
  input  logic [BL_W-1:0]  burst_len_i,
  output logic             cas_n_o,
  output logic             capture_o,
  output logic [BL_W-1:0]  beat_cnt_o,
  output logic             done_o,
  output logic             cfg_err_o,
  output logic             underrun_o
);
  localparam int CNT_W = BL_W + 1;

  seq_state_t      state_q;
  logic            seen_q, odd_q, half_q, rom_q;
  logic [BL_W-1:0] blen_q, beat_q;
  logic            cas_n_q, cap_q, done_q, cfg_q, under_q;

  logic load, adv, cur_bit, prev_bit, last_bit, cfg_bad;
  logic fall, rise, qualify, final_beat;
  logic [CNT_W-1:0] beat_nx;

  assign load = (state_q == ST_IDLE) && start_i;
  assign adv  = (state_q == ST_RUN);

  cas_shift_unit #(.PAT_W(PAT_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load), .adv_i(adv), .pattern_i(pattern_i),
    .cur_bit_o(cur_bit), .prev_bit_o(prev_bit), .last_bit_o(last_bit)
  );

  cas_pattern_check #(.PAT_W(PAT_W)) u_check (
    .pattern_i(pattern_i), .need_lead_i(half_clk_i | wide_i), .bad_o(cfg_bad)
  );

  assign fall       = prev_bit && !cur_bit;
  assign rise       = !prev_bit && cur_bit;
  assign qualify    = adv && seen_q && rise && (!half_q || odd_q);
  assign beat_nx    = {1'b0, beat_q} + CNT_W'(1);
  assign final_beat = qualify && (beat_nx == {1'b0, blen_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
      odd_q   <= 1'b0;
      half_q  <= 1'b0;
      rom_q   <= 1'b0;
      blen_q  <= '0;
      beat_q  <= '0;
      cas_n_q <= 1'b1;
      cap_q   <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= 1'b0;
      under_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cap_q  <= 1'b0;
          done_q <= 1'b0;
          if (start_i) begin
            state_q <= ST_RUN;
            cas_n_q <= 1'b1;
            beat_q  <= '0;
            seen_q  <= 1'b0;
            odd_q   <= 1'b0;
            under_q <= 1'b0;
            cfg_q   <= cfg_bad;
            blen_q  <= burst_len_i;
            half_q  <= half_clk_i;
            rom_q   <= rom_mode_i;
          end
        end
        ST_RUN: begin
          cap_q <= 1'b0;
          if (!seen_q) begin
            if (fall) begin
              cas_n_q <= 1'b0;
              seen_q  <= 1'b1;
            end
          end else if (rise) begin
            odd_q <= ~odd_q;
            if (rom_q) cas_n_q <= 1'b1;
            if (qualify) begin
              cap_q  <= 1'b1;
              beat_q <= beat_q + BL_W'(1);
              if (final_beat) state_q <= ST_FIN;
            end
          end
          if (last_bit && !final_beat) begin
            under_q <= 1'b1;
            cas_n_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_FIN: begin
          cap_q   <= 1'b0;
          done_q  <= 1'b1;
          cas_n_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cas_n_o    = cas_n_q;
  assign capture_o  = cap_q;
  assign beat_cnt_o = beat_q;
  assign done_o     = done_q;
  assign cfg_err_o  = cfg_q;
  assign underrun_o = under_q;

  // R5: capture pulses are single cycles
  assert_capture_single_R5: assert property (@(posedge clk) disable iff (rst)
    cap_q |=> !cap_q);
  // R5: never more beats than requested
  assert_beat_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (blen_q != '0) |-> (beat_q <= blen_q));
  // R7: completion follows a capture and releases the strobe
  assert_done_after_capture_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(cap_q) && cas_n_q));
  // R8: an underrun leaves the strobe released
  assert_underrun_cas_high_R8: assert property (@(posedge clk) disable iff (rst)
    under_q |-> cas_n_q);
  // R3: SDRAM strobe held low for the whole active burst
  assert_sdram_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && seen_q && !rom_q) |-> !cas_n_q);
  // R11: a start during an access changes no latched setting
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && start_i) |=> ($stable(blen_q) && $stable(half_q) && $stable(rom_q)));
endmodule

// File: tb/test_cas_seq_top.sv
module test_cas_seq_top;
  localparam int PW = 96;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst, start, rom, half, wide;
  logic [PW-1:0] pat;
  logic [BW-1:0] blen;
  logic          cas_n, cap, done, cfg_err, under;
  logic [BW-1:0] beat;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cas_seq_top #(.PAT_W(PW), .BL_W(BW)) i_cas_seq_top (
    .clk(clk), .rst(rst), .start_i(start), .pattern_i(pat), .rom_mode_i(rom),
    .half_clk_i(half), .wide_i(wide), .burst_len_i(blen), .cas_n_o(cas_n),
    .capture_o(cap), .beat_cnt_o(beat), .done_o(done), .cfg_err_o(cfg_err),
    .underrun_o(under)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mk_pat(input int lead, input int gap);
    logic [PW-1:0] v;
    for (int i = 0; i < PW; i++) begin
      if (i < lead) v[i] = 1'b1;
      else if (i < lead + gap) v[i] = 1'b0;
      else v[i] = ((i - lead - gap) % 2 == 0);
    end
    return v;
  endfunction

  task automatic run_gen(input int lead, input int gap, input int h, input int r,
                         input int w, input int bl);
    int  last_pos, endn, hi, jb;
    bit  complete;
    complete = 1'b0;
    last_pos = 0;
    if (bl != 0) begin
      jb = (h != 0) ? 2 * (bl - 1) + 1 : bl - 1;
      last_pos = lead + gap + 2 * jb;
      complete = (last_pos <= PW - 1);
    end
    endn = complete ? last_pos + 2 : PW;
    hi = (r != 0 && lead + gap + 1 < endn) ? lead + gap + 1 : endn;
    @(negedge clk);
    pat = mk_pat(lead, gap); rom = r[0]; half = h[0]; wide = w[0]; blen = bl[BW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 strobe high at start", cas_n, 1);
    for (int n = 1; n <= endn + 1; n++) begin
      int cnt, beats, pos;
      bit ecap;
      @(negedge clk);
      if (n == 3) start = 1'b0;
      cnt = 0; beats = 0; ecap = 1'b0;
      for (int j = 0; lead + gap + 2 * j <= PW - 1; j++) begin
        pos = lead + gap + 2 * j;
        if (h != 0 && j % 2 == 0) continue;
        if (bl != 0 && beats == bl) break;
        beats++;
        if (pos + 1 <= n) cnt++;
        if (pos + 1 == n) ecap = 1'b1;
      end
      chk((n == lead + 1) ? "R2 strobe fall" : ((r != 0) ? "R4 rom strobe" : "R3 sdram strobe"),
          cas_n, (n >= lead + 1 && n < hi) ? 0 : 1);
      chk((h != 0) ? "R6 half-rate capture" : "R5 capture", cap, ecap);
      chk("R5 beat count", beat, cnt % 16);
      chk("R7 done", done, (complete && n == endn) ? 1 : 0);
      chk("R8 underrun", under, (!complete && n >= PW) ? 1 : 0);
      if (n == 1)
        chk((h != 0 || w != 0) ? "R10 lead ones" : "R9 pattern rules", cfg_err,
            ((h != 0 || w != 0) && lead < 2) ? 1 : 0);
      if (n == 4)
        chk("R11 busy start ignored", cfg_err, ((h != 0 || w != 0) && lead < 2) ? 1 : 0);
      if (n == 2) begin
        start = 1'b1;
        pat = '0;
      end
    end
  endtask

  task automatic run_raw(input logic [PW-1:0] p, input int bl, input int exp_cfg,
                         input int exp_under, input string req);
    @(negedge clk);
    pat = p; rom = 1'b0; half = 1'b0; wide = 1'b0; blen = bl[BW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (done || under) break;
    end
    chk(req, cfg_err, exp_cfg);
    chk("R8 underrun flag", under, exp_under);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int leads [5] = '{1, 2, 3, 5, 7};
    logic [PW-1:0] p;
    rst = 1'b1; start = 1'b0; pat = '0; rom = 1'b0; half = 1'b0; wide = 1'b0; blen = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", cas_n, 1);
    chk("R1 reset capture", cap, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset beat", beat, 0);
    chk("R1 reset errors", {cfg_err, under}, 0);
    rst = 1'b0;

    foreach (leads[li])
      for (int g = 1; g <= 2; g++)
        for (int h = 0; h <= 1; h++)
          for (int r = 0; r <= 1; r++)
            for (int w = 0; w <= 1; w++)
              for (int bl = 0; bl <= 4; bl++)
                run_gen(leads[li], g, h, r, w, bl);

    // R12: final beat on bit 95 completes; two more ones push it past the end
    run_gen(66, 1, 0, 0, 0, 15);
    chk("R12 last-bit completion no underrun", under, 0);
    run_gen(68, 1, 0, 0, 0, 15);
    chk("R12 one edge short underruns", under, 1);

    run_raw({PW{1'b1}}, 1, 1, 1, "R9 no fall");
    run_raw(mk_pat(3, 3), 2, 1, 0, "R9 gap of three");
    p = mk_pat(3, 1);
    p[40] = ~p[40];
    run_raw(p, 2, 1, 0, "R9 broken alternation");
    run_raw(mk_pat(3, 2), 2, 0, 0, "R9 legal two-bit gap");

    // R1: reset in the middle of an access
    @(negedge clk);
    pat = mk_pat(3, 1); rom = 1'b0; half = 1'b0; wide = 1'b0; blen = 4'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-access reset strobe", cas_n, 1);
    chk("R1 mid-access reset beat", beat, 0);
    @(negedge clk);
    chk("R1 stays idle", {cap, done, under}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule